// File: doc/BRIEF.md
# Serial Control Port Register Bank

This block is a slave-only four-wire serial port that gives a host controller read and write access to a bank of fourteen 8-bit control registers. Each transfer is a 16-bit frame framed by an active-low select line. The frame opens with a direction bit, then a 7-bit register address, then an 8-bit data byte. The serial lines are brought into the system clock domain through a two-stage synchronizer before their edges are detected, so the serial clock must run well below the system clock.

The register contents are presented continuously on a flat parallel bus for the surrounding logic. Two status inputs report short-circuit events. Each one sets a flag bit in the output-level register, and the flag stays set until software overwrites it. The serial data output comes with a separate drive-enable, which a pad-level tri-state buffer combines into one shared line.

Top module: `spi_ctrl_regs`

## Requirements
- R1: After reset the registers hold these values: 0x01 and 0x02 hold 0x05; 0x03 and 0x04 hold 0x08; 0x07 holds 0x22; 0x08 holds 0x09; 0x11 holds 0x0F; 0x00, 0x05, 0x06, 0x09, 0x0A, 0x0C and 0x10 hold 0x00.
- R2: A frame is 16 bits. The first bit is the direction (0 write, 1 read), followed by address bits a6..a0 and then data bits d7..d0. When the sixteenth bit is captured with select still low, a write frame stores the data byte in the addressed register.
- R3: In a read frame, the addressed register's byte appears on the data output MSB first. Bit d(7-k) is launched on the rising serial clock edge of frame bit 9+k, so the host can sample it on the following falling edge.
- R4: The data input is captured on the falling serial clock edge. A value that is present only before the rising edge of a bit has no effect.
- R5: The output drive-enable is low while select is high, throughout write frames, and during the first eight bits of read frames.
- R6: A rising edge on select returns the port to idle. A frame cut short before its sixteenth bit changes no register, and the next frame is decoded from its first bit.
- R7: A read from any address outside the fourteen mapped ones returns 0xFF. A write to such an address changes no register.
- R8: In register 0x07, bit 7 is the right short-circuit flag and bit 3 is the left one. A one-cycle pulse on the matching status input sets the flag, the flag stays set after the pulse ends, and a register write replaces it with the written bit.
- R9: The parallel bus `regs_o` carries register slot k in bits [8k+7:8k]. Slots 0 to 10 hold addresses 0x00 to 0x0A, and slots 11, 12 and 13 hold addresses 0x0C, 0x10 and 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sck | input | 1 | Serial clock from the host |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial read data to the host |
| spi_sdo_en | output | 1 | Drive enable for the data output pad |
| short_left_i | input | 1 | Left short-circuit event pulse |
| short_right_i | input | 1 | Right short-circuit event pulse |
| regs_o | output | 112 | Parallel register contents, slot k in bits [8k+7:8k] |

## Verification
A wrong bit counter or a bad address capture shows up within one frame. It produces a wrong byte on the read-back of any address, or a write lands in a neighbouring slot, which the parallel bus reveals a few system clocks after the sixteenth falling edge. Sweeping all 128 addresses for read, write and read-back shows any error in the address decode or the reset values within that sweep. A sticky flag that is lost, or a partial frame that commits, shows on the next read of the affected register.

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs #(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spi_cs_n,
  input  logic         spi_sck,
  input  logic         spi_sdi,
  output logic         spi_sdo,
  output logic         spi_sdo_en,
  input  logic         short_left_i,
  input  logic         short_right_i,
  output logic [111:0] regs_o
);
  localparam int NREG     = 14;
  localparam int LVL_SLOT = 7;
  localparam int CNT_W    = 5;
  localparam int SH_W     = 15;

  function automatic logic [3:0] slot_of(input logic [6:0] a);
    if (a <= 7'h0A) return a[3:0];
    case (a)
      7'h0C:   return 4'd11;
      7'h10:   return 4'd12;
      7'h11:   return 4'd13;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int k);
    case (k)
      1, 2:    return 8'h05;
      3, 4:    return 8'h08;
      7:       return 8'h22;
      8:       return 8'h09;
      13:      return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  logic [SYNC_STAGES:0]   sck_p, cs_p;
  logic [SYNC_STAGES-1:0] sdi_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      sdi_p <= '0;
    end else begin
      sck_p <= {sck_p[SYNC_STAGES-1:0], spi_sck};
      cs_p  <= {cs_p[SYNC_STAGES-1:0], spi_cs_n};
      sdi_p <= {sdi_p[SYNC_STAGES-2:0], spi_sdi};
    end

  wire cs_s  = cs_p[SYNC_STAGES-1];
  wire sdi_s = sdi_p[SYNC_STAGES-1];
  wire rise  = sck_p[SYNC_STAGES-1] & ~sck_p[SYNC_STAGES];
  wire fall  = ~sck_p[SYNC_STAGES-1] & sck_p[SYNC_STAGES];

  logic [7:0]      bank [NREG];
  logic [SH_W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic            rw_q, out_q, drive_q;
  logic [6:0]      addr_q;
  logic [7:0]      rd_byte;

  wire [6:0] addr_now = {sh[5:0], sdi_s};
  wire [3:0] rd_slot  = slot_of(addr_now);
  wire [7:0] rd_val   = (rd_slot < 4'(NREG)) ? bank[rd_slot] : 8'hFF;
  wire       in_frame = ~cs_s & (cnt < CNT_W'(16));
  wire       wr_en    = fall & ~cs_s & (cnt == CNT_W'(15)) & ~rw_q;
  wire [7:0] wr_data  = {sh[6:0], sdi_s};
  wire [3:0] wr_slot  = slot_of(addr_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
      rd_byte <= '0;
      out_q   <= 1'b0;
      drive_q <= 1'b0;
    end else if (cs_s) begin
      cnt     <= '0;
      drive_q <= 1'b0;
    end else begin
      if (fall && in_frame) begin
        sh  <= {sh[SH_W-2:0], sdi_s};
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(7)) begin
          rw_q    <= sh[6];
          addr_q  <= addr_now;
          rd_byte <= rd_val;
        end
      end
      if (rise && in_frame && rw_q && cnt >= CNT_W'(8)) begin
        out_q   <= rd_byte[~cnt[2:0]];
        drive_q <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) bank[k] <= rst_val(k);
    end else begin
      for (int k = 0; k < NREG; k++)
        if (wr_en && wr_slot == 4'(k)) bank[k] <= wr_data;
      if (short_right_i) bank[LVL_SLOT][7] <= 1'b1;
      if (short_left_i)  bank[LVL_SLOT][3] <= 1'b1;
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = bank[g];
  end

  assign spi_sdo    = out_q;
  assign spi_sdo_en = drive_q;

  assert_quiet_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !short_left_i && !short_right_i) |=> $stable(regs_o))
    else $error("bank changed without a completed write");

  assert_unmapped_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == 4'hF && !short_left_i && !short_right_i) |=> $stable(regs_o))
    else $error("unmapped write altered the bank");

  assert_idle_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0))
    else $error("counter not cleared while deselected");

  assert_no_drive_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !spi_sdo_en)
    else $error("output driven while deselected");

  assert_drive_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sdo_en |-> (rw_q && cnt >= CNT_W'(8)))
    else $error("output driven outside a read data phase");

  assert_right_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    short_right_i |=> regs_o[LVL_SLOT*8+7])
    else $error("right flag not set");

  assert_left_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o[LVL_SLOT*8+3] && !wr_en) |=> regs_o[LVL_SLOT*8+3])
    else $error("left flag dropped");
endmodule

// File: tb/spi_ctrl_regs_bench.sv
module spi_ctrl_regs_bench;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_sdi = 1'b0;
  logic short_left_i = 1'b0, short_right_i = 1'b0;
  logic spi_sdo, spi_sdo_en;
  logic [111:0] regs_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_mem [128];

  always #5 clk = ~clk;

  spi_ctrl_regs u_spi_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_en(spi_sdo_en),
    .short_left_i(short_left_i), .short_right_i(short_right_i), .regs_o(regs_o)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  function automatic logic [6:0] slot_addr(input int s);
    if (s <= 10) return 7'(s);
    if (s == 11) return 7'h0C;
    if (s == 12) return 7'h10;
    return 7'h11;
  endfunction

  task automatic xfer(input bit rw, input logic [6:0] a, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rd, output bit quiet);
    logic [15:0] f;
    f = {rw, a, wd};
    rd = 8'h00;
    quiet = 1'b1;
    spi_cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = ~f[15-i];
      wait_clk(H-3);
      spi_sck = 1'b1;
      wait_clk(2);
      spi_sdi = f[15-i];
      wait_clk(H-2);
      if (rw && i >= 8) begin
        rd[15-i] = spi_sdo;
        if (!spi_sdo_en) quiet = 1'b0;
      end else if (spi_sdo_en) quiet = 1'b0;
      spi_sck = 1'b0;
      wait_clk(3);
    end
    wait_clk(H);
    spi_cs_n = 1'b1;
    wait_clk(H);
    if (spi_sdo_en) quiet = 1'b0;
  endtask

  task automatic check_bus(input string req);
    for (int s = 0; s < 14; s++) chk(req, regs_o[s*8 +: 8], exp_mem[slot_addr(s)]);
  endtask

  task automatic read_all(input string req);
    logic [7:0] rd;
    bit q;
    for (int a = 0; a < 128; a++) begin
      xfer(1'b1, 7'(a), 8'h00, 16, rd, q);
      chk(req, rd, exp_mem[a]);
    end
  endtask

  initial begin
    logic [7:0] rd;
    bit q;
    for (int a = 0; a < 128; a++) exp_mem[a] = 8'hFF;
    for (int s = 0; s < 14; s++) exp_mem[slot_addr(s)] = 8'h00;
    exp_mem[1] = 8'h05; exp_mem[2] = 8'h05; exp_mem[3] = 8'h08; exp_mem[4] = 8'h08;
    exp_mem[7] = 8'h22; exp_mem[8] = 8'h09; exp_mem[17] = 8'h0F;

    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R5 idle enable", {7'd0, spi_sdo_en}, 8'h00);
    check_bus("R1 R9 reset bus");
    read_all("R1 R7 reset readback");

    xfer(1'b1, 7'h07, 8'h00, 16, rd, q);
    chk("R3 read data phase enable", {7'd0, q}, 8'h01);

    for (int a = 0; a < 128; a++) begin
      logic [7:0] wd;
      wd = 8'(a * 29) ^ 8'hC3;
      xfer(1'b0, 7'(a), wd, 16, rd, q);
      if (a < 4) chk("R5 write frame quiet", {7'd0, q}, 8'h01);
      if (exp_mem[a] != 8'hFF || a <= 8'h11 && a != 8'h0B && a != 8'h0D &&
          a != 8'h0E && a != 8'h0F) exp_mem[a] = wd;
    end
    for (int a = 18; a < 128; a++) exp_mem[a] = 8'hFF;
    exp_mem[8'h0B] = 8'hFF; exp_mem[8'h0D] = 8'hFF; exp_mem[8'h0E] = 8'hFF; exp_mem[8'h0F] = 8'hFF;
    check_bus("R2 R4 R9 bus after writes");
    read_all("R2 R3 R7 readback after writes");

    xfer(1'b0, 7'h03, 8'h5A, 10, rd, q);
    xfer(1'b0, 7'h03, 8'hA6, 15, rd, q);
    chk("R6 aborted frame quiet", {7'd0, q}, 8'h01);
    xfer(1'b1, 7'h03, 8'h00, 16, rd, q);
    chk("R6 partial writes ignored", rd, exp_mem[3]);
    xfer(1'b1, 7'h11, 8'h00, 5, rd, q);
    xfer(1'b0, 7'h04, 8'h3C, 16, rd, q);
    exp_mem[4] = 8'h3C;
    xfer(1'b1, 7'h04, 8'h00, 16, rd, q);
    chk("R6 decode restarts after abort", rd, 8'h3C);

    xfer(1'b0, 7'h07, 8'h00, 16, rd, q);
    exp_mem[7] = 8'h00;
    short_right_i = 1'b1;
    wait_clk(1);
    short_right_i = 1'b0;
    wait_clk(3);
    exp_mem[7] = 8'h80;
    chk("R8 right flag on bus", regs_o[7*8 +: 8], 8'h80);
    short_left_i = 1'b1;
    wait_clk(1);
    short_left_i = 1'b0;
    wait_clk(20);
    exp_mem[7] = 8'h88;
    xfer(1'b1, 7'h07, 8'h00, 16, rd, q);
    chk("R8 flags persist", rd, 8'h88);
    xfer(1'b0, 7'h07, 8'h02, 16, rd, q);
    exp_mem[7] = 8'h02;
    xfer(1'b1, 7'h07, 8'h00, 16, rd, q);
    chk("R8 write clears flags", rd, 8'h02);
    check_bus("R9 final bus");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule